// File: doc/BRIEF.md
# Processing-Element Command Dispatcher

This block is the only path by which commands reach the execution engines of one processing element. Typed command descriptors arrive on a valid/ready intake port. For each command the block waits a programmable number of cycles, then routes it by opcode:

- DMA commands go to the DMA engine.
- Matrix-multiply commands go to the GEMM engine.
- Math commands go to the math engine.
- A composite whose operation is GEMM and that carries a B operand goes to a separate tiled sequencer.
- Any other composite is expanded in place: a math step on operand A, then a DMA write of A to the composite's output address.

Items flagged as non-commands bypass the overhead and leave unchanged on a pass-through port. Opcodes that match nothing complete at once. Each command carries a tag. The engine that runs a command echoes the tag on its done channel, and the block forwards it as a completion. Internal steps of an expanded composite are not reported as completions.

Several commands may be in flight at the same time, so completion is tracked per tag. A command whose tag is still outstanding is held back until that tag completes. Every output port holds its command until it is accepted. A stalled engine therefore cannot lose or reorder work.

Top module: `pe_cmd_dispatch`

## Requirements
- R1: Opcode 0 (read, `dma_wr`=0) and opcode 1 (write, `dma_wr`=1) go to the DMA port, with `dma_addr`=A, `dma_loc`=B, `dma_len`=length and the tag.
- R2: Opcode 2 goes to the GEMM port with A, B and tag. Opcode 3 goes to the math port with function, A and tag.
- R3: With an overhead setting of N, the engine port's valid rises N+1 clock edges after the intake edge. N=0 adds no wait.
- R4: Opcodes 5 to 7 raise `cpl_valid` with their tag within a few cycles, and no engine or sequencer port asserts valid.
- R5: Opcode 4 with `in_cgemm`=1 and `in_has_b`=1 goes to the sequencer port carrying A, B, output address and tag. Any other opcode-4 command takes the math-composite path.
- R6: The math-composite path issues a math op on A, using function 0 (identity) when `in_has_fn`=0. The math done does not complete the command. After it, a DMA write of A (`dma_loc`=A) to the output address with the output length is issued. Its done then completes the tag.
- R7: An intake item with `in_is_cmd`=0 appears on the pass-through port as `pt_word`=A and `pt_tag`=tag. It has no overhead and no completion.
- R8: A new command may be dispatched while others are outstanding. Each engine done raises `cpl_valid` for one cycle with the echoed tag, in the order the dones arrive.
- R9: A port with valid high and ready low keeps valid and its fields stable. The intake stays not-ready until that port accepts.
- R10: A command whose tag is still outstanding is not dispatched until that tag's completion has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovh_cycles | input | OVW | Overhead cycles applied to each command |
| in_valid | input | 1 | Intake item valid |
| in_ready | output | 1 | Intake can accept |
| in_is_cmd | input | 1 | 1 = command, 0 = pass-through item |
| in_op | input | 3 | Opcode: 0 DMA read, 1 DMA write, 2 GEMM, 3 math, 4 composite, others unknown |
| in_tag | input | TAG_W | Command tag, echoed on completion |
| in_a | input | AW | Operand A address (pass-through word) |
| in_b | input | AW | Operand B address / DMA local address |
| in_has_b | input | 1 | B operand present |
| in_cgemm | input | 1 | Composite operation is GEMM |
| in_fn | input | FW | Math function |
| in_has_fn | input | 1 | Math function given |
| in_out | input | AW | Output address |
| in_len | input | LW | Byte count |
| pt_valid | output | 1 | Pass-through valid |
| pt_ready | input | 1 | Pass-through accept |
| pt_word | output | AW | Pass-through word |
| pt_tag | output | TAG_W | Pass-through tag |
| dma_valid | output | 1 | DMA command valid |
| dma_ready | input | 1 | DMA engine accept |
| dma_wr | output | 1 | 1 = write, 0 = read |
| dma_addr | output | AW | Remote address |
| dma_loc | output | AW | Local buffer address |
| dma_len | output | LW | Byte count |
| dma_tag | output | TAG_W | Tag |
| gemm_valid | output | 1 | GEMM command valid |
| gemm_ready | input | 1 | GEMM engine accept |
| gemm_a | output | AW | Operand A |
| gemm_b | output | AW | Operand B |
| gemm_tag | output | TAG_W | Tag |
| math_valid | output | 1 | Math command valid |
| math_ready | input | 1 | Math engine accept |
| math_fn | output | FW | Function |
| math_addr | output | AW | Operand (in place) |
| math_tag | output | TAG_W | Tag |
| seq_valid | output | 1 | Tiled-sequencer command valid |
| seq_ready | input | 1 | Sequencer accept |
| seq_a | output | AW | Operand A |
| seq_b | output | AW | Operand B |
| seq_out | output | AW | Output address |
| seq_tag | output | TAG_W | Tag |
| dma_done | input | 1 | DMA done valid |
| dma_done_ready | output | 1 | DMA done accepted |
| dma_done_tag | input | TAG_W | DMA done tag |
| gemm_done | input | 1 | GEMM done valid |
| gemm_done_ready | output | 1 | GEMM done accepted |
| gemm_done_tag | input | TAG_W | GEMM done tag |
| math_done | input | 1 | Math done valid |
| math_done_ready | output | 1 | Math done accepted |
| math_done_tag | input | TAG_W | Math done tag |
| seq_done | input | 1 | Sequencer done valid |
| seq_done_ready | output | 1 | Sequencer done accepted |
| seq_done_tag | input | TAG_W | Sequencer done tag |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | TAG_W | Completed tag |

## Verification
A tag bit left set by mistake shows at the ports as a later command with the same tag that never reaches its engine. That hang appears as soon as the tag is reused. A bit cleared too early shows up the other way: a duplicate-tag command is dispatched before the first one's completion. A composite context stuck in its math step swallows the math done and never issues the follow-up DMA write, so the missing write shows within a cycle of the done handshake. An overhead counter off by one moves the rise of the engine valid by exactly one edge relative to the intake edge.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;
  localparam logic [2:0] OP_DMA_RD = 3'd0;
  localparam logic [2:0] OP_DMA_WR = 3'd1;
  localparam logic [2:0] OP_GEMM   = 3'd2;
  localparam logic [2:0] OP_MATH   = 3'd3;
  localparam logic [2:0] OP_COMP   = 3'd4;

  typedef enum logic [2:0] {RT_DMA, RT_GEMM, RT_MATH, RT_SEQ, RT_CMATH, RT_UNK} route_e;
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ROUTE, S_HOLD, S_PT} main_e;
  typedef enum logic [1:0] {C_IDLE, C_MATH, C_WRP, C_WRW} ctx_e;

  localparam int NSRC    = 5;
  localparam int SRC_DMA = 0;
  localparam int SRC_GEM = 1;
  localparam int SRC_MTH = 2;
  localparam int SRC_SEQ = 3;
  localparam int SRC_UNK = 4;

  function automatic route_e decode(input logic [2:0] op, input logic cgemm, input logic has_b);
    case (op)
      OP_DMA_RD, OP_DMA_WR: return RT_DMA;
      OP_GEMM:              return RT_GEMM;
      OP_MATH:              return RT_MATH;
      OP_COMP:              return (cgemm && has_b) ? RT_SEQ : RT_CMATH;
      default:              return RT_UNK;
    endcase
  endfunction
endpackage

// File: rtl/pcd_ovh_timer.sv
`timescale 1ns/1ps
module pcd_ovh_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pcd_tag_track.sv
`timescale 1ns/1ps
module pcd_tag_track #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [(1<<TAG_W)-1:0] busy
);
  localparam int NT = 1 << TAG_W;

  for (genvar g = 0; g < NT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                         busy[g] <= 1'b0;
      else if (set_en && set_tag == TAG_W'(g))         busy[g] <= 1'b1;
      else if (clr_en && clr_tag == TAG_W'(g))         busy[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcd_cpl_merge.sv
`timescale 1ns/1ps
module pcd_cpl_merge #(
  parameter int TAG_W = 4,
  parameter int NS    = 5,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0]       req,
  input  logic [NS*TAG_W-1:0] tags,
  output logic [NS-1:0]       gnt,
  output logic                gnt_any,
  output logic [SW-1:0]       gnt_idx,
  output logic [TAG_W-1:0]    gnt_tag
);
  always_comb begin
    gnt     = '0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    gnt_tag = '0;
    for (int i = 0; i < NS; i++) begin
      if (req[i] && !gnt_any) begin
        gnt[i]  = 1'b1;
        gnt_any = 1'b1;
        gnt_idx = SW'(i);
        gnt_tag = tags[i*TAG_W +: TAG_W];
      end
    end
  end
endmodule

// File: rtl/pe_cmd_dispatch.sv
`timescale 1ns/1ps
module pe_cmd_dispatch
  import pcd_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int FW    = 4,
  parameter int OVW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OVW-1:0]   ovh_cycles,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_cmd,
  input  logic [2:0]       in_op,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [AW-1:0]    in_a,
  input  logic [AW-1:0]    in_b,
  input  logic             in_has_b,
  input  logic             in_cgemm,
  input  logic [FW-1:0]    in_fn,
  input  logic             in_has_fn,
  input  logic [AW-1:0]    in_out,
  input  logic [LW-1:0]    in_len,
  output logic             pt_valid,
  input  logic             pt_ready,
  output logic [AW-1:0]    pt_word,
  output logic [TAG_W-1:0] pt_tag,
  output logic             dma_valid,
  input  logic             dma_ready,
  output logic             dma_wr,
  output logic [AW-1:0]    dma_addr,
  output logic [AW-1:0]    dma_loc,
  output logic [LW-1:0]    dma_len,
  output logic [TAG_W-1:0] dma_tag,
  output logic             gemm_valid,
  input  logic             gemm_ready,
  output logic [AW-1:0]    gemm_a,
  output logic [AW-1:0]    gemm_b,
  output logic [TAG_W-1:0] gemm_tag,
  output logic             math_valid,
  input  logic             math_ready,
  output logic [FW-1:0]    math_fn,
  output logic [AW-1:0]    math_addr,
  output logic [TAG_W-1:0] math_tag,
  output logic             seq_valid,
  input  logic             seq_ready,
  output logic [AW-1:0]    seq_a,
  output logic [AW-1:0]    seq_b,
  output logic [AW-1:0]    seq_out,
  output logic [TAG_W-1:0] seq_tag,
  input  logic             dma_done,
  output logic             dma_done_ready,
  input  logic [TAG_W-1:0] dma_done_tag,
  input  logic             gemm_done,
  output logic             gemm_done_ready,
  input  logic [TAG_W-1:0] gemm_done_tag,
  input  logic             math_done,
  output logic             math_done_ready,
  input  logic [TAG_W-1:0] math_done_tag,
  input  logic             seq_done,
  output logic             seq_done_ready,
  input  logic [TAG_W-1:0] seq_done_tag,
  output logic             cpl_valid,
  output logic [TAG_W-1:0] cpl_tag
);
  localparam int NT = 1 << TAG_W;
  localparam int SW = $clog2(NSRC);
  localparam logic [FW-1:0] FN_IDENT = '0;

  main_e st;
  ctx_e  ctx_st;

  logic [2:0]       r_op;
  logic [TAG_W-1:0] r_tag;
  logic [AW-1:0]    r_a, r_b, r_out;
  logic             r_has_b, r_cgemm, r_has_fn;
  logic [FW-1:0]    r_fn;
  logic [LW-1:0]    r_len;

  logic [TAG_W-1:0] ctx_tag;
  logic [AW-1:0]    ctx_a, ctx_out;
  logic [LW-1:0]    ctx_len;

  logic             unk_req;
  route_e           route;
  logic             go;
  logic             tag_free;
  logic [NT-1:0]    busy;
  logic             tmr_zero;
  logic             accept;
  logic             main_dma_load, ctx_load;

  logic [NSRC-1:0]       m_req, m_gnt;
  logic [NSRC*TAG_W-1:0] m_tags;
  logic                  m_any;
  logic [SW-1:0]         m_idx;
  logic [TAG_W-1:0]      m_tag;
  logic                  internal;
  logic                  cpl_fire;

  assign in_ready = (st == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign route    = decode(r_op, r_cgemm, r_has_b);
  assign tag_free = !busy[r_tag];

  always_comb begin
    go = 1'b0;
    if (st == S_ROUTE) begin
      case (route)
        RT_DMA:   go = tag_free && !dma_valid && (ctx_st != C_WRP);
        RT_CMATH: go = tag_free && (ctx_st == C_IDLE);
        RT_UNK:   go = 1'b1;
        default:  go = tag_free;
      endcase
    end
  end

  assign main_dma_load = go && (route == RT_DMA);
  assign ctx_load      = (ctx_st == C_WRP) && !dma_valid && !main_dma_load;

  pcd_ovh_timer #(.W(OVW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(accept && in_is_cmd && (ovh_cycles != '0)),
    .len  (ovh_cycles - 1'b1),
    .zero (tmr_zero)
  );

  // Main intake / dispatch FSM
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pt_valid   <= 1'b0;
      gemm_valid <= 1'b0;
      math_valid <= 1'b0;
      seq_valid  <= 1'b0;
      unk_req    <= 1'b0;
      pt_word    <= '0;
      pt_tag     <= '0;
      r_op       <= '0;
      r_tag      <= '0;
      r_a        <= '0;
      r_b        <= '0;
      r_out      <= '0;
      r_has_b    <= 1'b0;
      r_cgemm    <= 1'b0;
      r_has_fn   <= 1'b0;
      r_fn       <= '0;
      r_len      <= '0;
      gemm_a     <= '0;
      gemm_b     <= '0;
      gemm_tag   <= '0;
      math_fn    <= '0;
      math_addr  <= '0;
      math_tag   <= '0;
      seq_a      <= '0;
      seq_b      <= '0;
      seq_out    <= '0;
      seq_tag    <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          if (!in_is_cmd) begin
            pt_valid <= 1'b1;
            pt_word  <= in_a;
            pt_tag   <= in_tag;
            st       <= S_PT;
          end else begin
            r_op     <= in_op;
            r_tag    <= in_tag;
            r_a      <= in_a;
            r_b      <= in_b;
            r_out    <= in_out;
            r_has_b  <= in_has_b;
            r_cgemm  <= in_cgemm;
            r_has_fn <= in_has_fn;
            r_fn     <= in_fn;
            r_len    <= in_len;
            st       <= (ovh_cycles == '0) ? S_ROUTE : S_WAIT;
          end
        end
        S_WAIT: if (tmr_zero) st <= S_ROUTE;
        S_ROUTE: if (go) begin
          case (route)
            RT_GEMM: begin
              gemm_valid <= 1'b1;
              gemm_a     <= r_a;
              gemm_b     <= r_b;
              gemm_tag   <= r_tag;
            end
            RT_MATH, RT_CMATH: begin
              math_valid <= 1'b1;
              math_fn    <= (route == RT_MATH || r_has_fn) ? r_fn : FN_IDENT;
              math_addr  <= r_a;
              math_tag   <= r_tag;
            end
            RT_SEQ: begin
              seq_valid <= 1'b1;
              seq_a     <= r_a;
              seq_b     <= r_b;
              seq_out   <= r_out;
              seq_tag   <= r_tag;
            end
            RT_UNK:  unk_req <= 1'b1;
            default: ;
          endcase
          st <= S_HOLD;
        end
        S_HOLD: begin
          case (route)
            RT_DMA: if (dma_valid && dma_ready) st <= S_IDLE;
            RT_GEMM: if (gemm_ready) begin
              gemm_valid <= 1'b0;
              st         <= S_IDLE;
            end
            RT_MATH, RT_CMATH: if (math_ready) begin
              math_valid <= 1'b0;
              st         <= S_IDLE;
            end
            RT_SEQ: if (seq_ready) begin
              seq_valid <= 1'b0;
              st        <= S_IDLE;
            end
            default: if (m_gnt[SRC_UNK]) begin
              unk_req <= 1'b0;
              st      <= S_IDLE;
            end
          endcase
        end
        S_PT: if (pt_ready) begin
          pt_valid <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // DMA port: shared by direct commands and the composite write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_valid <= 1'b0;
      dma_wr    <= 1'b0;
      dma_addr  <= '0;
      dma_loc   <= '0;
      dma_len   <= '0;
      dma_tag   <= '0;
    end else if (main_dma_load) begin
      dma_valid <= 1'b1;
      dma_wr    <= (r_op == OP_DMA_WR);
      dma_addr  <= r_a;
      dma_loc   <= r_b;
      dma_len   <= r_len;
      dma_tag   <= r_tag;
    end else if (ctx_load) begin
      dma_valid <= 1'b1;
      dma_wr    <= 1'b1;
      dma_addr  <= ctx_out;
      dma_loc   <= ctx_a;
      dma_len   <= ctx_len;
      dma_tag   <= ctx_tag;
    end else if (dma_valid && dma_ready) begin
      dma_valid <= 1'b0;
    end
  end

  // Completion merge
  assign m_req  = {unk_req, seq_done, math_done, gemm_done, dma_done};
  assign m_tags = {r_tag, seq_done_tag, math_done_tag, gemm_done_tag, dma_done_tag};

  pcd_cpl_merge #(.TAG_W(TAG_W), .NS(NSRC)) u_merge (
    .req    (m_req),
    .tags   (m_tags),
    .gnt    (m_gnt),
    .gnt_any(m_any),
    .gnt_idx(m_idx),
    .gnt_tag(m_tag)
  );

  assign dma_done_ready  = m_gnt[SRC_DMA];
  assign gemm_done_ready = m_gnt[SRC_GEM];
  assign math_done_ready = m_gnt[SRC_MTH];
  assign seq_done_ready  = m_gnt[SRC_SEQ];

  assign internal = m_any && (m_idx == SW'(SRC_MTH)) && (ctx_st == C_MATH) && (m_tag == ctx_tag);
  assign cpl_fire = m_any && !internal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
    end else begin
      cpl_valid <= cpl_fire;
      if (cpl_fire) cpl_tag <= m_tag;
    end
  end

  // Math-composite context
  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_st  <= C_IDLE;
      ctx_tag <= '0;
      ctx_a   <= '0;
      ctx_out <= '0;
      ctx_len <= '0;
    end else begin
      case (ctx_st)
        C_IDLE: if (go && route == RT_CMATH) begin
          ctx_st  <= C_MATH;
          ctx_tag <= r_tag;
          ctx_a   <= r_a;
          ctx_out <= r_out;
          ctx_len <= r_len;
        end
        C_MATH:  if (internal) ctx_st <= C_WRP;
        C_WRP:   if (ctx_load) ctx_st <= C_WRW;
        default: if (m_any && m_idx == SW'(SRC_DMA) && m_tag == ctx_tag) ctx_st <= C_IDLE;
      endcase
    end
  end

  pcd_tag_track #(.TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .set_en (go && route != RT_UNK),
    .set_tag(r_tag),
    .clr_en (cpl_fire),
    .clr_tag(m_tag),
    .busy   (busy)
  );
endmodule

// File: rtl/pcd_checker.sv
`timescale 1ns/1ps
module pcd_checker #(
  parameter int TAG_W = 4,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             pt_valid,
  input logic             pt_ready,
  input logic [AW-1:0]    pt_word,
  input logic             dma_valid,
  input logic             dma_ready,
  input logic [AW-1:0]    dma_addr,
  input logic [TAG_W-1:0] dma_tag,
  input logic             gemm_valid,
  input logic             gemm_ready,
  input logic [AW-1:0]    gemm_a,
  input logic             math_valid,
  input logic             math_ready,
  input logic [AW-1:0]    math_addr,
  input logic             seq_valid,
  input logic             seq_ready,
  input logic [AW-1:0]    seq_a
);
  p_dma_hold_r9: assert property (@(posedge clk) disable iff (rst)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_tag));
  p_gemm_hold_r9: assert property (@(posedge clk) disable iff (rst)
    gemm_valid && !gemm_ready |=> gemm_valid && $stable(gemm_a));
  p_math_hold_r9: assert property (@(posedge clk) disable iff (rst)
    math_valid && !math_ready |=> math_valid && $stable(math_addr));
  p_seq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    seq_valid && !seq_ready |=> seq_valid && $stable(seq_a));
  p_pt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    pt_valid && !pt_ready |=> pt_valid && $stable(pt_word));
  p_intake_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !gemm_valid && !math_valid && !seq_valid && !pt_valid);
  p_one_owner_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({gemm_valid, math_valid, seq_valid, pt_valid}) <= 1);
endmodule

bind pe_cmd_dispatch pcd_checker #(.TAG_W(TAG_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_word(pt_word),
  .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr), .dma_tag(dma_tag),
  .gemm_valid(gemm_valid), .gemm_ready(gemm_ready), .gemm_a(gemm_a),
  .math_valid(math_valid), .math_ready(math_ready), .math_addr(math_addr),
  .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_a(seq_a)
);

// File: tb/sim_pe_cmd_dispatch.sv
`timescale 1ns/1ps
module sim_pe_cmd_dispatch;
  localparam int TAG_W = 4, AW = 32, LW = 16, FW = 4, OVW = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [OVW-1:0] ovh_cycles = '0;
  logic in_valid = 0, in_is_cmd = 0, in_has_b = 0, in_cgemm = 0, in_has_fn = 0;
  logic [2:0] in_op = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [AW-1:0] in_a = '0, in_b = '0, in_out = '0;
  logic [FW-1:0] in_fn = '0;
  logic [LW-1:0] in_len = '0;
  logic in_ready;
  logic pt_valid, pt_ready = 1;
  logic [AW-1:0] pt_word;
  logic [TAG_W-1:0] pt_tag;
  logic dma_valid, dma_ready = 1, dma_wr;
  logic [AW-1:0] dma_addr, dma_loc;
  logic [LW-1:0] dma_len;
  logic [TAG_W-1:0] dma_tag;
  logic gemm_valid, gemm_ready = 1;
  logic [AW-1:0] gemm_a, gemm_b;
  logic [TAG_W-1:0] gemm_tag;
  logic math_valid, math_ready = 1;
  logic [FW-1:0] math_fn;
  logic [AW-1:0] math_addr;
  logic [TAG_W-1:0] math_tag;
  logic seq_valid, seq_ready = 1;
  logic [AW-1:0] seq_a, seq_b, seq_out;
  logic [TAG_W-1:0] seq_tag;
  logic dma_done = 0, gemm_done = 0, math_done = 0, seq_done = 0;
  logic dma_done_ready, gemm_done_ready, math_done_ready, seq_done_ready;
  logic [TAG_W-1:0] dma_done_tag = '0, gemm_done_tag = '0, math_done_tag = '0, seq_done_tag = '0;
  logic cpl_valid;
  logic [TAG_W-1:0] cpl_tag;

  pe_cmd_dispatch #(.TAG_W(TAG_W), .AW(AW), .LW(LW), .FW(FW), .OVW(OVW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit is_cmd, input logic [2:0] op, input logic [TAG_W-1:0] tag,
                      input logic [AW-1:0] a, input logic [AW-1:0] b, input bit has_b,
                      input bit cg, input logic [FW-1:0] fn, input bit has_fn,
                      input logic [AW-1:0] outa, input logic [LW-1:0] len);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_is_cmd = is_cmd; in_op = op; in_tag = tag; in_a = a; in_b = b;
    in_has_b = has_b; in_cgemm = cg; in_fn = fn; in_has_fn = has_fn; in_out = outa; in_len = len;
    @(negedge clk);
    in_valid = 0;
  endtask

  // which: 0 dma, 1 gemm, 2 math, 3 seq; returns edges waited (99 = never)
  task automatic wait_port(input int which, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      logic v;
      case (which)
        0: v = dma_valid;
        1: v = gemm_valid;
        2: v = math_valid;
        default: v = seq_valid;
      endcase
      if (v) return;
      @(negedge clk);
      n++;
    end
    n = 99;
  endtask

  task automatic give_done(input int which, input logic [TAG_W-1:0] tag);
    bit r;
    case (which)
      0: begin dma_done = 1; dma_done_tag = tag; end
      1: begin gemm_done = 1; gemm_done_tag = tag; end
      2: begin math_done = 1; math_done_tag = tag; end
      default: begin seq_done = 1; seq_done_tag = tag; end
    endcase
    for (int i = 0; i < 40; i++) begin
      #1;
      case (which)
        0: r = dma_done_ready;
        1: r = gemm_done_ready;
        2: r = math_done_ready;
        default: r = seq_done_ready;
      endcase
      @(negedge clk);
      if (r) break;
    end
    dma_done = 0; gemm_done = 0; math_done = 0; seq_done = 0;
  endtask

  task automatic t_reset();
    chk(cpl_valid == 0 && dma_valid == 0 && gemm_valid == 0 && math_valid == 0
        && seq_valid == 0 && pt_valid == 0, "reset outputs idle", 64'(cpl_valid), 0);
    chk(in_ready == 1, "reset intake ready", 64'(in_ready), 1);
  endtask

  task automatic t_dma();
    int n;
    send(1, 3'd0, 4'd1, 32'hA000, 32'hB000, 0, 0, 0, 0, 0, 16'd64);
    wait_port(0, n);
    chk(n == 1, "R3 zero overhead", 64'(n), 1);
    chk(dma_wr == 0 && dma_addr == 32'hA000 && dma_loc == 32'hB000 && dma_len == 64 && dma_tag == 1,
        "R1 dma read fields", 64'(dma_addr), 64'hA000);
    give_done(0, 4'd1);
    chk(cpl_valid && cpl_tag == 1, "R8 dma completion", 64'(cpl_tag), 1);
    send(1, 3'd1, 4'd2, 32'hA100, 32'hB100, 0, 0, 0, 0, 0, 16'd32);
    wait_port(0, n);
    chk(dma_wr == 1 && dma_addr == 32'hA100 && dma_tag == 2, "R1 dma write fields", 64'(dma_wr), 1);
    give_done(0, 4'd2);
    chk(cpl_valid && cpl_tag == 2, "R8 dma write completion", 64'(cpl_tag), 2);
  endtask

  task automatic t_overhead();
    int n;
    ovh_cycles = 8'd5;
    send(1, 3'd0, 4'd3, 32'hC000, 0, 0, 0, 0, 0, 0, 16'd8);
    wait_port(0, n);
    chk(n == 6, "R3 overhead of 5", 64'(n), 6);
    give_done(0, 4'd3);
    ovh_cycles = 8'd0;
  endtask

  task automatic t_gemm_math();
    int n;
    send(1, 3'd2, 4'd4, 32'h1111, 32'h2222, 1, 0, 0, 0, 0, 0);
    wait_port(1, n);
    chk(n != 99 && gemm_a == 32'h1111 && gemm_b == 32'h2222 && gemm_tag == 4,
        "R2 gemm port", 64'(gemm_a), 64'h1111);
    give_done(1, 4'd4);
    chk(cpl_valid && cpl_tag == 4, "R2 gemm completion", 64'(cpl_tag), 4);
    send(1, 3'd3, 4'd5, 32'h3333, 0, 0, 0, 4'd9, 1, 0, 0);
    wait_port(2, n);
    chk(n != 99 && math_fn == 9 && math_addr == 32'h3333 && math_tag == 5,
        "R2 math port", 64'(math_fn), 9);
    give_done(2, 4'd5);
    chk(cpl_valid && cpl_tag == 5, "R2 math completion", 64'(cpl_tag), 5);
  endtask

  task automatic t_unknown();
    bit any_eng = 0, got = 0;
    logic [TAG_W-1:0] t = '0;
    send(1, 3'd6, 4'd7, 32'h5, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin
      if (dma_valid || gemm_valid || math_valid || seq_valid) any_eng = 1;
      if (cpl_valid) begin got = 1; t = cpl_tag; end
      @(negedge clk);
    end
    chk(got && t == 7, "R4 unknown completes", 64'(t), 7);
    chk(!any_eng, "R4 unknown touches no engine", 64'(any_eng), 0);
  endtask

  task automatic t_seq();
    int n;
    send(1, 3'd4, 4'd8, 32'h4000, 32'h5000, 1, 1, 0, 0, 32'h6000, 16'd100);
    wait_port(3, n);
    chk(n != 99 && seq_a == 32'h4000 && seq_b == 32'h5000 && seq_out == 32'h6000 && seq_tag == 8,
        "R5 gemm composite to sequencer", 64'(seq_out), 64'h6000);
    give_done(3, 4'd8);
    chk(cpl_valid && cpl_tag == 8, "R5 sequencer completion", 64'(cpl_tag), 8);
  endtask

  task automatic t_cmath(input bit cg, input bit hb, input bit hf, input logic [FW-1:0] fn,
                         input logic [TAG_W-1:0] tag, input string rq);
    int n;
    logic [FW-1:0] efn;
    efn = hf ? fn : 4'd0;
    send(1, 3'd4, tag, 32'h7000, 32'h7100, hb, cg, fn, hf, 32'h8000, 16'd48);
    wait_port(2, n);
    chk(n != 99 && math_fn == efn && math_addr == 32'h7000 && math_tag == tag,
        {rq, " math step"}, 64'(math_fn), 64'(efn));
    repeat (4) @(negedge clk);
    chk(!dma_valid, "R6 no write before math done", 64'(dma_valid), 0);
    give_done(2, tag);
    chk(!cpl_valid, "R6 math step not a completion", 64'(cpl_valid), 0);
    wait_port(0, n);
    chk(n == 1 && dma_wr == 1 && dma_addr == 32'h8000 && dma_loc == 32'h7000 && dma_len == 48,
        "R6 write-back fields", 64'(dma_addr), 64'h8000);
    give_done(0, tag);
    chk(cpl_valid && cpl_tag == tag, "R6 composite completion", 64'(cpl_tag), 64'(tag));
  endtask

  task automatic t_passthru();
    send(0, 3'd2, 4'd9, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0);
    chk(pt_valid && pt_word == 32'hDEAD_BEEF && pt_tag == 9, "R7 pass-through", 64'(pt_word), 64'hDEADBEEF);
    chk(!gemm_valid, "R7 pass-through not routed", 64'(gemm_valid), 0);
  endtask

  task automatic t_concurrent();
    int n;
    send(1, 3'd2, 4'd10, 32'h10, 32'h20, 1, 0, 0, 0, 0, 0);
    wait_port(1, n);
    send(1, 3'd0, 4'd11, 32'h30, 32'h40, 0, 0, 0, 0, 0, 16'd4);
    wait_port(0, n);
    chk(n != 99 && dma_tag == 11, "R8 dispatch while outstanding", 64'(dma_tag), 11);
    give_done(0, 4'd11);
    chk(cpl_valid && cpl_tag == 11, "R8 first completion", 64'(cpl_tag), 11);
    give_done(1, 4'd10);
    chk(cpl_valid && cpl_tag == 10, "R8 second completion", 64'(cpl_tag), 10);
    @(negedge clk);
    chk(!cpl_valid, "R8 completion is one cycle", 64'(cpl_valid), 0);
  endtask

  task automatic t_stall();
    int n;
    bit held = 1;
    dma_ready = 0;
    send(1, 3'd0, 4'd12, 32'hE1, 0, 0, 0, 0, 0, 0, 16'd1);
    wait_port(0, n);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!dma_valid || dma_addr != 32'hE1 || in_ready) held = 0;
    end
    chk(held, "R9 stalled port holds", 64'(dma_addr), 64'hE1);
    dma_ready = 1;
    @(negedge clk);
    dma_ready = 0;
    send(1, 3'd0, 4'd13, 32'hE2, 0, 0, 0, 0, 0, 0, 16'd1);
    wait_port(0, n);
    chk(dma_addr == 32'hE2 && dma_tag == 13, "R9 second after release", 64'(dma_addr), 64'hE2);
    dma_ready = 1;
    @(negedge clk);
    give_done(0, 4'd12);
    give_done(0, 4'd13);
  endtask

  task automatic t_tagbusy();
    int n;
    bit seen = 0;
    send(1, 3'd2, 4'd3, 32'h90, 32'h91, 1, 0, 0, 0, 0, 0);
    wait_port(1, n);
    send(1, 3'd0, 4'd3, 32'h92, 0, 0, 0, 0, 0, 0, 16'd2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dma_valid) seen = 1;
    end
    chk(!seen, "R10 duplicate tag held", 64'(seen), 0);
    give_done(1, 4'd3);
    wait_port(0, n);
    chk(n != 99 && dma_addr == 32'h92 && dma_tag == 3, "R10 released after completion", 64'(dma_addr), 64'h92);
    give_done(0, 4'd3);
    chk(cpl_valid && cpl_tag == 3, "R10 completion", 64'(cpl_tag), 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_dma();
    t_overhead();
    t_gemm_math();
    t_unknown();
    t_seq();
    t_cmath(0, 1, 0, 4'd5, 4'd14, "R5 non-gemm composite");
    t_cmath(1, 0, 0, 4'd0, 4'd15, "R5 gemm composite without B");
    t_cmath(0, 0, 1, 4'd6, 4'd2, "R6 given function");
    t_passthru();
    t_concurrent();
    t_stall();
    t_tagbusy();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule